// File: doc/BRIEF.md
# Parallel Flash Bus Strobe Front End

This block sits between the pads of an emulated parallel NOR-style memory and its internal logic. It oversamples the active-low chip-enable, output-enable, write-enable and reset pins, and the address and data pads, on the system clock. From the synchronized pins it decides when a read cycle is open. During a read it drives the word returned by the memory array onto the data pads, and at all other times it holds the pad drivers off.

For writes, the block follows the two-strobe rule. A write cycle is open while chip-enable and write-enable are both low. The address is taken at the moment the later of the two strobes falls, and the data at the moment the earlier of the two rises. Each completed write cycle is handed to a downstream command decoder as one single-clock event that carries the captured address and data word.

A write that sees output-enable low at any time while it is open is dropped. A low level on the emulated reset pin floats the bus, blocks reads and abandons any open write.

Top module: `pflash_strobe_if`

## Requirements
- R1: While the system reset is asserted, and after it is released with all pins high, `rd_active`, `pin_dq_oe` and `wr_valid` are all 0.
- R2: When chip-enable and output-enable are low and write-enable and the reset pin are high, `rd_active` and `pin_dq_oe` become 1 within 5 clocks. `arr_rd_addr` equals `pin_addr`, and `pin_dq_o` carries `arr_rd_data`. If write-enable is low, no read is opened.
- R3: Whenever chip-enable or output-enable is high, `pin_dq_oe` is 0, with at most 3 clocks of synchronizer latency.
- R4: A write with chip-enable low first and a write-enable low pulse produces one `wr_valid` event carrying the captured address and data.
- R5: A write with write-enable low first and a chip-enable low pulse produces one `wr_valid` event carrying the captured address and data.
- R6: The address reported is the one present when the later strobe falls. Address changes before that moment, and after it while the cycle is open, do not affect the event.
- R7: The data reported is the value present when the earlier strobe rises. Data changes after that rise do not affect the event. All 16 bits are passed unchanged.
- R8: A write cycle during which output-enable is low at any time produces no event.
- R9: While the reset pin is low, `pin_dq_oe` and `rd_active` are 0 and no event is produced. A write cycle open when the reset pin goes low is abandoned without an event.
- R10: `wr_valid` is high for exactly one clock per completed write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| pin_ce_n | input | 1 | Chip-enable pad, active low |
| pin_oe_n | input | 1 | Output-enable pad, active low |
| pin_we_n | input | 1 | Write-enable pad, active low |
| pin_rst_n | input | 1 | Emulated device reset pad, active low |
| pin_addr | input | ADDR_W | Address pads |
| pin_dq_i | input | DATA_W | Data pad input path |
| pin_dq_o | output | DATA_W | Data pad output path (zero when not driving) |
| pin_dq_oe | output | 1 | Data pad driver enable |
| arr_rd_addr | output | ADDR_W | Synchronized address to the memory array |
| arr_rd_data | input | DATA_W | Word returned by the memory array |
| rd_active | output | 1 | A read cycle is open |
| wr_valid | output | 1 | One-clock write event |
| wr_addr | output | ADDR_W | Address of the write event |
| wr_data | output | DATA_W | Data of the write event |

## Verification
If the write tracker sticks in its open state, the next write is either lost or reported with a stale address. The scoreboard shows this on the next expected event, about three clocks after the earlier strobe rises. If the tracker fails to record a spoiled cycle, an unexpected event shows up at the end of that cycle. If the read enable register misbehaves, `pin_dq_oe` disagrees with the strobe levels within three clocks of a pin change, which is where the bench samples after every read and float step. If the address capture register is wrong, `wr_addr` shows either the pre-fall or the post-fall garbage address that the driver applies on purpose.

// File: rtl/pflash_pkg.sv
`timescale 1ns/1ps
package pflash_pkg;
  // write cycle tracker states
  typedef enum logic [1:0] {
    WC_IDLE    = 2'd0,
    WC_OPEN    = 2'd1,
    WC_SPOILED = 2'd2
  } wc_state_e;

  // bit positions inside the synchronized control vector
  localparam int CTL_CE  = 0;
  localparam int CTL_OE  = 1;
  localparam int CTL_WE  = 2;
  localparam int CTL_RST = 3;
  localparam int CTL_W   = 4;
endpackage

// File: rtl/pflash_rst_sync.sv
`timescale 1ns/1ps
module pflash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pflash_sync.sv
`timescale 1ns/1ps
module pflash_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pflash_read_gate.sv
`timescale 1ns/1ps
module pflash_read_gate #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              prst_n,
  input  logic [DATA_W-1:0] arr_data,
  output logic              rd_active,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_o
);
  logic rd_en_d;
  logic rd_en_q;

  always_comb begin
    rd_en_d = !ce_n && !oe_n && we_n && prst_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
    end else begin
      rd_en_q <= rd_en_d;
    end
  end

  assign rd_active = rd_en_q;
  assign dq_oe     = rd_en_q;
  assign dq_o      = rd_en_q ? arr_data : '0;
endmodule

// File: rtl/pflash_write_capture.sv
`timescale 1ns/1ps
module pflash_write_capture
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              prst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  wc_state_e         state_q, state_d;
  logic              both_low;
  logic              addr_en;
  logic              fire;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_comb begin
    both_low = !ce_n && !we_n;
    state_d  = state_q;
    addr_en  = 1'b0;
    fire     = 1'b0;
    unique case (state_q)
      WC_IDLE: begin
        // later strobe has just fallen: take the address
        if (prst_n && both_low) begin
          addr_en = 1'b1;
          state_d = oe_n ? WC_OPEN : WC_SPOILED;
        end
      end
      WC_OPEN: begin
        if (!prst_n) begin
          state_d = WC_IDLE;
        end else if (!both_low) begin
          // earlier strobe has just risen: take the data
          fire    = oe_n;
          state_d = WC_IDLE;
        end else if (!oe_n) begin
          state_d = WC_SPOILED;
        end
      end
      WC_SPOILED: begin
        if (!prst_n || !both_low) begin
          state_d = WC_IDLE;
        end
      end
      default: state_d = WC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WC_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (fire) begin
      data_q <= dq;
    end
  end

  assign wr_valid = valid_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
endmodule

// File: rtl/pflash_strobe_if.sv
`timescale 1ns/1ps
module pflash_strobe_if
  import pflash_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_ce_n,
  input  logic              pin_oe_n,
  input  logic              pin_we_n,
  input  logic              pin_rst_n,
  input  logic [ADDR_W-1:0] pin_addr,
  input  logic [DATA_W-1:0] pin_dq_i,
  output logic [DATA_W-1:0] pin_dq_o,
  output logic              pin_dq_oe,
  output logic [ADDR_W-1:0] arr_rd_addr,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic              rd_active,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              rst_n_int;
  logic [CTL_W-1:0]  ctl_raw;
  logic [CTL_W-1:0]  ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] dq_s;
  logic              s_ce_n, s_oe_n, s_we_n, s_rst_n;

  pflash_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_int)
  );

  always_comb begin
    ctl_raw          = '1;
    ctl_raw[CTL_CE]  = pin_ce_n;
    ctl_raw[CTL_OE]  = pin_oe_n;
    ctl_raw[CTL_WE]  = pin_we_n;
    ctl_raw[CTL_RST] = pin_rst_n;
  end

  pflash_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
    .clk (clk), .rst_n (rst_n_int), .d (ctl_raw), .q (ctl_s)
  );

  pflash_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk (clk), .rst_n (rst_n_int), .d (pin_addr), .q (addr_s)
  );

  pflash_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dq (
    .clk (clk), .rst_n (rst_n_int), .d (pin_dq_i), .q (dq_s)
  );

  assign s_ce_n  = ctl_s[CTL_CE];
  assign s_oe_n  = ctl_s[CTL_OE];
  assign s_we_n  = ctl_s[CTL_WE];
  assign s_rst_n = ctl_s[CTL_RST];

  assign arr_rd_addr = addr_s;

  pflash_read_gate #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ce_n      (s_ce_n),
    .oe_n      (s_oe_n),
    .we_n      (s_we_n),
    .prst_n    (s_rst_n),
    .arr_data  (arr_rd_data),
    .rd_active (rd_active),
    .dq_oe     (pin_dq_oe),
    .dq_o      (pin_dq_o)
  );

  pflash_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ce_n     (s_ce_n),
    .oe_n     (s_oe_n),
    .we_n     (s_we_n),
    .prst_n   (s_rst_n),
    .addr     (addr_s),
    .dq       (dq_s),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );
endmodule

// File: rtl/pflash_strobe_if_chk.sv
`timescale 1ns/1ps
module pflash_strobe_if_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ce_n,
  input logic              s_oe_n,
  input logic              s_we_n,
  input logic              s_rst_n,
  input logic [DATA_W-1:0] s_dq,
  input logic              rd_active,
  input logic              pin_dq_oe,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data
);
  // R2: open read condition leads to an active read next clock
  a_r2_read_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ce_n && !s_oe_n && s_we_n && s_rst_n) |=> rd_active);

  // R3: either enable high leads to floating pads next clock
  a_r3_float: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ce_n || s_oe_n) |=> !pin_dq_oe);

  // R7: event data is the synchronized bus value at the closing clock
  a_r7_data_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data == $past(s_dq)));

  // R8: no event when output-enable was low at the closing clock
  a_r8_oe_high_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(s_oe_n));

  // R9: reset pin low silences reads and events
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !s_rst_n |=> (!rd_active && !wr_valid));

  // R10: events are one clock wide
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
endmodule

bind pflash_strobe_if pflash_strobe_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .s_ce_n    (s_ce_n),
  .s_oe_n    (s_oe_n),
  .s_we_n    (s_we_n),
  .s_rst_n   (s_rst_n),
  .s_dq      (dq_s),
  .rd_active (rd_active),
  .pin_dq_oe (pin_dq_oe),
  .wr_valid  (wr_valid),
  .wr_data   (wr_data)
);

// File: tb/sim_pflash_strobe_if.sv
`timescale 1ns/1ps
module sim_pflash_strobe_if;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk, rst_n;
  logic          ce_n, oe_n, we_n, prst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_i, dq_o, rd_data;
  logic          dq_oe, rd_active, wr_valid;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  int n_seen = 0;
  int n_pushed = 0;
  bit done = 0;
  bit prev_valid = 0;
  logic [AW+DW-1:0] exp_q[$];

  pflash_strobe_if u0 (
    .clk (clk), .rst_n (rst_n),
    .pin_ce_n (ce_n), .pin_oe_n (oe_n), .pin_we_n (we_n), .pin_rst_n (prst_n),
    .pin_addr (addr), .pin_dq_i (dq_i), .pin_dq_o (dq_o), .pin_dq_oe (dq_oe),
    .arr_rd_addr (rd_addr), .arr_rd_data (rd_data),
    .rd_active (rd_active), .wr_valid (wr_valid),
    .wr_addr (wr_addr), .wr_data (wr_data)
  );

  // array model: word derived from address
  assign rd_data = rd_addr[DW-1:0] ^ 16'hA5C3;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_valid) begin
        logic [AW+DW-1:0] item;
        checks++;
        n_seen++;
        if (prev_valid) begin
          errors++;
          $display("FAIL R10: wr_valid high two clocks, actual 1 expected 0");
        end
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8 R9: unexpected event actual %0h/%0h expected none", wr_addr, wr_data);
        end else begin
          item = exp_q.pop_front();
          if ({wr_addr, wr_data} !== item) begin
            errors++;
            $display("FAIL R4 R5 R6 R7: event actual %0h/%0h expected %0h/%0h",
                     wr_addr, wr_data, item[AW+DW-1:DW], item[DW-1:0]);
          end
        end
      end
      prev_valid = wr_valid;
    end
  end

  task automatic do_read(input logic [AW-1:0] a);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    nclk(5);
    check(rd_active === 1'b1, "R2 rd_active", rd_active, 1);
    check(dq_oe === 1'b1, "R2 drive enable", dq_oe, 1);
    check(rd_addr === a, "R2 array address", rd_addr, a);
    check(dq_o === (a[DW-1:0] ^ 16'hA5C3), "R2 read word", dq_o, a[DW-1:0] ^ 16'hA5C3);
    oe_n = 1'b1;
    nclk(4);
    check(dq_oe === 1'b0, "R3 float on oe high", dq_oe, 0);
    oe_n = 1'b0; ce_n = 1'b1;
    nclk(4);
    check(dq_oe === 1'b0, "R3 float on ce high", dq_oe, 0);
    oe_n = 1'b1;
    nclk(3);
  endtask

  // driver side: ce_ctrl=1 means write-enable falls first and chip-enable pulses
  task automatic do_write(input bit ce_ctrl, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit spoil_oe, input bit rst_abort);
    oe_n = 1'b1; ce_n = 1'b1; we_n = 1'b1;
    addr = ~a; dq_i = ~d;
    nclk(2);
    if (ce_ctrl) we_n = 1'b0; else ce_n = 1'b0;
    nclk(4);
    addr = a; dq_i = d;          // R6: value before the later fall is what counts
    nclk(2);
    if (ce_ctrl) ce_n = 1'b0; else we_n = 1'b0;
    nclk(4);
    addr = a ^ 20'h0F0F5;        // R6: change after the later fall must be ignored
    check(dq_oe === 1'b0, "R3 no drive during write", dq_oe, 0);
    if (spoil_oe) begin
      oe_n = 1'b0; nclk(3); oe_n = 1'b1; nclk(2);
    end
    if (rst_abort) begin
      prst_n = 1'b0; nclk(4);
    end
    nclk(2);
    if (!spoil_oe && !rst_abort) begin
      exp_q.push_back({a, d});
      n_pushed++;
    end
    if (ce_ctrl) ce_n = 1'b1; else we_n = 1'b1;
    nclk(4);
    dq_i = d ^ 16'h5A5A;         // R7: change after the earlier rise must be ignored
    nclk(3);
    if (ce_ctrl) we_n = 1'b1; else ce_n = 1'b1;
    nclk(3);
    prst_n = 1'b1;
    nclk(6);
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; prst_n = 1'b1;
    addr = '0; dq_i = '0;
    nclk(3);
    check(rd_active === 1'b0, "R1 rd_active in reset", rd_active, 0);
    check(dq_oe === 1'b0, "R1 dq_oe in reset", dq_oe, 0);
    check(wr_valid === 1'b0, "R1 wr_valid in reset", wr_valid, 0);
    rst_n = 1'b1;
    nclk(6);
    check(rd_active === 1'b0, "R1 rd_active after reset", rd_active, 0);
    check(dq_oe === 1'b0, "R1 dq_oe after reset", dq_oe, 0);

    do_read(20'h12345);
    do_read(20'hFFFFF);
    do_read(20'h00000);

    // R2: write-enable low blocks a read (also an oe-low write attempt, R8)
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    nclk(5);
    check(dq_oe === 1'b0, "R2 we low blocks read", dq_oe, 0);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    nclk(6);
    check(n_seen == n_pushed, "R8 no event from oe-low attempt", n_seen, n_pushed);

    do_write(1'b0, 20'h00555, 16'h12AA, 1'b0, 1'b0);  // R4
    do_write(1'b1, 20'h002AA, 16'hFF55, 1'b0, 1'b0);  // R5
    do_write(1'b0, 20'hABCDE, 16'h8030, 1'b0, 1'b0);  // R4
    do_write(1'b1, 20'hFFFFF, 16'hFFFF, 1'b0, 1'b0);  // R5
    check(n_seen == 4, "R4 R5 events seen", n_seen, 4);

    do_write(1'b0, 20'h11111, 16'h2222, 1'b1, 1'b0);  // R8
    check(n_seen == n_pushed, "R8 spoiled write silent", n_seen, n_pushed);
    do_write(1'b1, 20'h33333, 16'h4444, 1'b0, 1'b1);  // R9
    check(n_seen == n_pushed, "R9 aborted write silent", n_seen, n_pushed);
    do_write(1'b1, 20'h00001, 16'h0001, 1'b0, 1'b0);  // recovery after abort

    // R9: reset pin low blocks a read
    prst_n = 1'b0; addr = 20'h00777; ce_n = 1'b0; oe_n = 1'b0;
    nclk(5);
    check(dq_oe === 1'b0, "R9 float under reset pin", dq_oe, 0);
    check(rd_active === 1'b0, "R9 no read under reset pin", rd_active, 0);
    prst_n = 1'b1;
    nclk(5);
    check(rd_active === 1'b1, "R9 read resumes", rd_active, 1);
    ce_n = 1'b1; oe_n = 1'b1;
    nclk(10);

    check(exp_q.size() == 0, "R10 all expected events seen", exp_q.size(), 0);
    check(n_seen == n_pushed, "R10 one event per write", n_seen, n_pushed);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule